// File: doc/BRIEF.md
# Variable-Tap Delay Line

This block is a multi-bit delay line built from a chain of registers. On every clock edge where the enable is high, the input word enters the first stage and every stored word moves one stage further along. The output comes from one of two places. In fixed mode it is always the last stage. In variable mode an address input chooses the stage, so the delay can be changed at run time without rebuilding the block.

An optional output register follows the tap. It has three synchronous controls, and when more than one is high the priority is: clear (all zeros), then set (all ones), then initialize (a value given by a parameter). A parameter decides whether these controls need the enable to be high or act on their own. Width, depth, address width and every option are parameters. Elaboration-time checks reject configurations that cannot work.

Top module: `tapline_delay`

## Requirements
- R1: At a rising edge with `ce` high, `din` enters stage 0 and each stage k takes the old value of stage k-1. With `ce` low, every stage keeps its value.
- R2: Variable mode with the output register (`VARIABLE`=1, `REG_OUT`=1), no control active and `ce` high: after the edge, `q` holds the word pushed `addr`+1 enabled edges before that edge. This is zero if fewer words have been pushed since reset.
- R3: Fixed mode (`VARIABLE`=0) ignores `addr` and always taps stage `DEPTH`-1.
- R4: Without the output register (`REG_OUT`=0), `q` follows the selected stage in the same cycle as the shift. In fixed mode a word therefore appears `DEPTH` enabled edges after it was pushed.
- R5: With the controls live, `sclr` high loads all zeros into `q`, whatever `sset` and `sinit` are.
- R6: With the controls live, `sset` high and `sclr` low load all ones into `q`, whatever `sinit` is.
- R7: With the controls live, `sinit` high and `sclr`, `sset` low load `INIT_VAL` into `q`.
- R8: With `CTRL_IGNORES_CE`=0, the controls are live only when `ce` is high. When `ce` is low, `q` holds whatever the controls are.
- R9: With `CTRL_IGNORES_CE`=1, the controls are live whatever `ce` is. With `ce` low and no control high, `q` holds.
- R10: An edge with `rst_n` low clears every stage and `q` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset, clears all stages and the output |
| ce | input | 1 | Clock enable for shifting and loading the output |
| addr | input | ADDR_W | Tap select in variable mode, clamped to DEPTH-1 |
| sclr | input | 1 | Synchronous clear of the output register |
| sset | input | 1 | Synchronous set of the output register |
| sinit | input | 1 | Synchronous load of INIT_VAL into the output register |
| din | input | WIDTH | Word pushed into stage 0 |
| q | output | WIDTH | Delayed word |

## Verification
The bench builds three 8-bit instances that share the same stimulus:
- a registered variable-tap line of 8 stages whose controls depend on the enable;
- the same line with controls that ignore the enable and a different init value;
- an unregistered fixed line of 5 stages.

With eight stages and a 3-bit address, the bench can sweep every tap position. Every combination of enable, clear, set and initialize is applied to both control policies. Because the 5-stage fixed line is not a power of two long, it checks that the final tap ignores the shared address. A second reset while the stages hold data shows that the stored words are really cleared.

// File: rtl/tapline_pkg.sv
`timescale 1ns/1ps
package tapline_pkg;

   // Decision taken by the output stage on each edge.
   typedef enum logic [2:0] {
      ACT_HOLD = 3'd0,
      ACT_TAP  = 3'd1,
      ACT_ZERO = 3'd2,
      ACT_ONES = 3'd3,
      ACT_INIT = 3'd4
   } out_act_e;

   // Clear wins over set, set wins over init; controls only count when live.
   function automatic out_act_e pick_action(input logic live, input logic ce,
                                            input logic clr, input logic set,
                                            input logic init);
      if (live && clr)  return ACT_ZERO;
      if (live && set)  return ACT_ONES;
      if (live && init) return ACT_INIT;
      if (ce)           return ACT_TAP;
      return ACT_HOLD;
   endfunction

endpackage

// File: rtl/tapline_chain.sv
`timescale 1ns/1ps
module tapline_chain #(
   parameter int WIDTH = 16,
   parameter int DEPTH = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   shift_en,
   input  logic [WIDTH-1:0]       din,
   output logic [DEPTH*WIDTH-1:0] stages_o
);

   logic [WIDTH-1:0] stg [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      logic [WIDTH-1:0] feed;
      if (i == 0) begin : g_head
         assign feed = din;
      end else begin : g_body
         assign feed = stg[i-1];
      end

      always_ff @(posedge clk) begin
         if (!rst_n)        stg[i] <= '0;
         else if (shift_en) stg[i] <= feed;
      end

      assign stages_o[i*WIDTH +: WIDTH] = stg[i];
   end

endmodule

// File: rtl/tapline_select.sv
`timescale 1ns/1ps
module tapline_select #(
   parameter int WIDTH    = 16,
   parameter int DEPTH    = 16,
   parameter int ADDR_W   = 4,
   parameter bit VARIABLE = 1'b1
) (
   input  logic [DEPTH*WIDTH-1:0] stages_i,
   input  logic [ADDR_W-1:0]      addr,
   output logic [WIDTH-1:0]       tap_o
);

   localparam int LAST = DEPTH - 1;

   if (VARIABLE) begin : g_var
      logic [ADDR_W-1:0] idx;
      if (DEPTH == (1 << ADDR_W)) begin : g_full
         assign idx = addr;
      end else begin : g_clamp
         localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(LAST);
         assign idx = (addr > LAST_A) ? LAST_A : addr;
      end
      assign tap_o = stages_i[int'(idx)*WIDTH +: WIDTH];
   end else begin : g_fixed
      logic [ADDR_W-1:0] addr_unused;
      assign addr_unused = addr;
      assign tap_o = stages_i[LAST*WIDTH +: WIDTH];
   end

endmodule

// File: rtl/tapline_outreg.sv
`timescale 1ns/1ps
module tapline_outreg
   import tapline_pkg::*;
#(
   parameter int               WIDTH           = 16,
   parameter bit               REG_OUT         = 1'b1,
   parameter bit               CTRL_IGNORES_CE = 1'b0,
   parameter logic [WIDTH-1:0] INIT_VAL        = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce,
   input  logic             sclr,
   input  logic             sset,
   input  logic             sinit,
   input  logic [WIDTH-1:0] tap_i,
   output logic [WIDTH-1:0] q
);

   if (REG_OUT) begin : g_reg
      logic     live;
      out_act_e act;
      assign live = CTRL_IGNORES_CE ? 1'b1 : ce;
      assign act  = pick_action(live, ce, sclr, sset, sinit);

      always_ff @(posedge clk) begin
         if (!rst_n) q <= '0;
         else begin
            case (act)
               ACT_ZERO: q <= '0;
               ACT_ONES: q <= '1;
               ACT_INIT: q <= INIT_VAL;
               ACT_TAP:  q <= tap_i;
               default:  q <= q;
            endcase
         end
      end
   end else begin : g_wire
      assign q = tap_i;
   end

endmodule

// File: rtl/tapline_delay.sv
`timescale 1ns/1ps
module tapline_delay #(
   parameter int               WIDTH           = 16,
   parameter int               DEPTH           = 16,
   parameter int               ADDR_W          = 4,
   parameter bit               VARIABLE        = 1'b1,
   parameter bit               REG_OUT         = 1'b1,
   parameter bit               CTRL_IGNORES_CE = 1'b0,
   parameter logic [WIDTH-1:0] INIT_VAL        = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce,
   input  logic [ADDR_W-1:0] addr,
   input  logic              sclr,
   input  logic              sset,
   input  logic              sinit,
   input  logic [WIDTH-1:0]  din,
   output logic [WIDTH-1:0]  q
);

   localparam int FLAT_W = DEPTH * WIDTH;

   if (WIDTH < 1) begin : g_bad_width
      $error("tapline_delay: WIDTH must be at least 1");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("tapline_delay: DEPTH must be at least 2");
   end
   if ((1 << ADDR_W) < DEPTH) begin : g_bad_addr
      $error("tapline_delay: ADDR_W too narrow to reach every stage");
   end

   logic [FLAT_W-1:0] stages;
   logic [WIDTH-1:0]  tap;

   tapline_chain #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (ce),
      .din      (din),
      .stages_o (stages)
   );

   tapline_select #(
      .WIDTH(WIDTH), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .VARIABLE(VARIABLE)
   ) u_select (
      .stages_i (stages),
      .addr     (addr),
      .tap_o    (tap)
   );

   tapline_outreg #(
      .WIDTH(WIDTH), .REG_OUT(REG_OUT),
      .CTRL_IGNORES_CE(CTRL_IGNORES_CE), .INIT_VAL(INIT_VAL)
   ) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .ce    (ce),
      .sclr  (sclr),
      .sset  (sset),
      .sinit (sinit),
      .tap_i (tap),
      .q     (q)
   );

endmodule

// File: rtl/tapline_delay_chk.sv
`timescale 1ns/1ps
module tapline_delay_chk #(
   parameter int               WIDTH           = 16,
   parameter int               ADDR_W          = 4,
   parameter bit               REG_OUT         = 1'b1,
   parameter bit               CTRL_IGNORES_CE = 1'b0,
   parameter logic [WIDTH-1:0] INIT_VAL        = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce,
   input logic [ADDR_W-1:0] addr,
   input logic              sclr,
   input logic              sset,
   input logic              sinit,
   input logic [WIDTH-1:0]  din,
   input logic [WIDTH-1:0]  q
);

   logic live;
   assign live = CTRL_IGNORES_CE ? 1'b1 : ce;

   // R10: a reset edge leaves the output at zero
   p_reset_clears_r10: assert property (@(posedge clk) !rst_n |=> q == '0);

   if (REG_OUT) begin : g_reg_props
      p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
         live && sclr |=> q == '0);
      p_set_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
         live && sset && !sclr |=> q == '1);
      p_init_val_r7: assert property (@(posedge clk) disable iff (!rst_n)
         live && sinit && !sset && !sclr |=> q == INIT_VAL);

      if (CTRL_IGNORES_CE) begin : g_free
         p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !ce && !sclr && !sset && !sinit |=> $stable(q));
      end else begin : g_gated
         p_gated_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !ce |=> $stable(q));
      end
   end

   logic unused_ok;
   assign unused_ok = ^{addr, din};

endmodule

bind tapline_delay tapline_delay_chk #(
   .WIDTH(WIDTH), .ADDR_W(ADDR_W), .REG_OUT(REG_OUT),
   .CTRL_IGNORES_CE(CTRL_IGNORES_CE), .INIT_VAL(INIT_VAL)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ce(ce), .addr(addr), .sclr(sclr),
   .sset(sset), .sinit(sinit), .din(din), .q(q)
);

// File: tb/tapline_delay_tb_top.sv
`timescale 1ns/1ps
module tapline_delay_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ce = 1'b0;
   logic [2:0] addr = '0;
   logic       sclr = 1'b0, sset = 1'b0, sinit = 1'b0;
   logic [7:0] din = '0;
   logic [7:0] q_i, q_g, q_f;

   int errors = 0;
   int checks = 0;
   int cnt    = 0;
   logic [7:0] exp_i = '0, exp_g = '0;

   always #5 clk = ~clk;

   tapline_delay #(.WIDTH(8), .DEPTH(8), .ADDR_W(3), .VARIABLE(1'b1),
      .REG_OUT(1'b1), .CTRL_IGNORES_CE(1'b0), .INIT_VAL(8'hA5)) dut_i (
      .clk(clk), .rst_n(rst_n), .ce(ce), .addr(addr), .sclr(sclr),
      .sset(sset), .sinit(sinit), .din(din), .q(q_i));

   tapline_delay #(.WIDTH(8), .DEPTH(8), .ADDR_W(3), .VARIABLE(1'b1),
      .REG_OUT(1'b1), .CTRL_IGNORES_CE(1'b1), .INIT_VAL(8'h3C)) dut_g (
      .clk(clk), .rst_n(rst_n), .ce(ce), .addr(addr), .sclr(sclr),
      .sset(sset), .sinit(sinit), .din(din), .q(q_g));

   tapline_delay #(.WIDTH(8), .DEPTH(5), .ADDR_W(3), .VARIABLE(1'b0),
      .REG_OUT(1'b0), .CTRL_IGNORES_CE(1'b0), .INIT_VAL(8'h00)) dut_f (
      .clk(clk), .rst_n(rst_n), .ce(ce), .addr(addr), .sclr(sclr),
      .sset(sset), .sinit(sinit), .din(din), .q(q_f));

   // Word pushed as the k-th enabled push since reset; before any push a stage reads zero.
   function automatic logic [7:0] fv(input int k);
      if (k < 0) return 8'h00;
      return 8'(k * 37 + 11);
   endfunction

   task automatic chk(input string req, input string who, input logic [7:0] act,
                      input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%02h expected=%02h", req, who, act, exp);
      end
   endtask

   task automatic tick(input logic r, input logic ce_v, input logic [2:0] a,
                       input logic c, input logic s, input logic n, input string tag);
      logic [7:0] tap, nx_i, nx_g, exp_f;
      @(negedge clk);
      rst_n = r; ce = ce_v; addr = a; sclr = c; sset = s; sinit = n;
      din = ce_v ? fv(cnt) : 8'hEE;
      tap = fv(cnt - 1 - int'(a));
      // enable-gated controls
      if (!r)                   nx_i = 8'h00;
      else if (ce_v && c)       nx_i = 8'h00;
      else if (ce_v && s)       nx_i = 8'hFF;
      else if (ce_v && n)       nx_i = 8'hA5;
      else if (ce_v)            nx_i = tap;
      else                      nx_i = exp_i;
      // controls independent of enable
      if (!r)                   nx_g = 8'h00;
      else if (c)               nx_g = 8'h00;
      else if (s)               nx_g = 8'hFF;
      else if (n)               nx_g = 8'h3C;
      else if (ce_v)            nx_g = tap;
      else                      nx_g = exp_g;
      @(posedge clk);
      #1;
      if (!r) cnt = 0;
      else if (ce_v) cnt++;
      exp_i = nx_i;
      exp_g = nx_g;
      exp_f = fv(cnt - 5);
      chk(tag, "dut_i", q_i, exp_i);
      chk(tag, "dut_g", q_g, exp_g);
      chk("R3,R4", "dut_f", q_f, exp_f);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      // R10: reset state with enable and input active
      for (int i = 0; i < 3; i++) tick(1'b0, 1'b1, 3'd5, 1'b0, 1'b0, 1'b0, "R10");

      // R2: sweep every tap with continuous pushes
      for (int a = 0; a < 8; a++)
         for (int i = 0; i < 12; i++)
            tick(1'b1, 1'b1, 3'(a), 1'b0, 1'b0, 1'b0, "R2");

      // R1: irregular enable, stages must hold on idle edges
      for (int i = 0; i < 24; i++)
         tick(1'b1, (i % 3) != 0, 3'(i % 8), 1'b0, 1'b0, 1'b0, "R1");

      // R5..R9: every mix of enable and controls, with a plain push between
      for (int c = 0; c < 16; c++) begin
         string tg;
         if (c[0])      tg = "R5";
         else if (c[1]) tg = "R6";
         else if (c[2]) tg = "R7";
         else           tg = "R8,R9";
         if (!c[3] && (c[2:0] != 3'b000)) tg = {tg, ",R8,R9"};
         tick(1'b1, c[3], 3'(c % 8), c[0], c[1], c[2], tg);
         tick(1'b1, 1'b1, 3'((c + 3) % 8), 1'b0, 1'b0, 1'b0, "R2");
      end

      // R10: reset while stages are full, then old data must not reappear
      tick(1'b0, 1'b1, 3'd7, 1'b0, 1'b0, 1'b0, "R10");
      for (int i = 0; i < 10; i++) tick(1'b1, 1'b1, 3'd7, 1'b0, 1'b0, 1'b0, "R10");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule